// File: doc/BRIEF.md
# Packed Halfword Shift and Shuffle Unit

The unit operates on 64-bit words treated as four packed 16-bit lanes. It shifts every lane by the same amount without letting bits leak into a neighbouring lane, and it rearranges lanes in two ways. Mix interleaves alternate lanes of two source words, at 16-bit or 32-bit granularity. Permute builds a word from any choice of lanes of one source, and the same source lane may be chosen more than once.

Lanes are numbered from the left. Lane 0 occupies bits 63:48 and lane 3 occupies bits 15:0. Each operation is computed in one stage of logic and is then held in a single output register. Operations arrive on a valid/ready input and leave on a valid/ready output. The input is ready when the output register is empty or is being emptied in the same cycle. A result that is not taken stays put, unchanged, until the consumer raises `res_ready`. Eight mix operations are enough to transpose a 4x4 matrix of halfwords held in four words.

Top module: `subword_shuffle_unit`

## Requirements
- R1: `req_ready` equals `!res_valid || res_ready`. An operation accepted on a clock edge (`req_valid && req_ready`) appears on `res_data` with `res_valid` high after exactly one edge. Results leave in the order they were accepted.
- R2: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` does not change.
- R3: During and after reset, `res_valid` is low until the first accepted operation.
- R4: Opcode 0 is an arithmetic right shift. Each lane is shifted right by `req_shamt` and filled on the left with copies of that lane's bit 15.
- R5: Opcode 1 is a logical right shift. Each lane is shifted right by `req_shamt` and filled on the left with zeros.
- R6: Opcode 2 is a left shift. Each lane is shifted left by `req_shamt` and filled on the right with zeros. Bits pushed out of the top of a lane are discarded, and no lane receives bits from another lane.
- R7: `req_shamt` is 4 bits wide (0 to 15). An amount of 0 returns the source unchanged for all three shifts.
- R8: Opcode 3 is 16-bit mix-left and gives lanes {A0,B0,A2,B2}. Opcode 4 is 16-bit mix-right and gives {A1,B1,A3,B3}. A is `req_src_a` and B is `req_src_b`.
- R9: Opcode 5 is 32-bit mix-left and gives halves {A0,B0}. Opcode 6 is 32-bit mix-right and gives {A1,B1}. Halves are numbered from the left.
- R10: Opcode 7 is permute. Destination lane k (counting from the left) takes source-A lane `req_perm[7-2k:6-2k]`, so the leftmost lane uses bits 7:6. The value 8'h1B reproduces A. The value 8'hE4 reverses the lanes.
- R11: `req_src_b` has no effect on shifts or permute. `req_shamt` has no effect on mix or permute. `req_perm` has no effect on any other opcode.
- R12: The four words produced by mix16-left/right on row pairs (0,1) and (2,3), followed by mix32-left/right on the resulting pairs, hold the columns of the 4x4 halfword matrix formed by those rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation offered |
| req_ready | output | 1 | Operation can be taken this cycle |
| req_op | input | 3 | Opcode (see R4 to R10) |
| req_src_a | input | 64 | First source word |
| req_src_b | input | 64 | Second source word (mix only) |
| req_shamt | input | 4 | Per-lane shift amount |
| req_perm | input | 8 | Permute selector, 2 bits per destination lane |
| res_valid | output | 1 | Result held |
| res_ready | input | 1 | Consumer takes result |
| res_data | output | 64 | Result word |

## Verification
Two events can land on the same edge: a held result leaving on `res_ready` and a new operation entering through the combinational `req_ready`. The bench drives `req_valid` and `res_ready` at random, so same-edge hand-over, stall-with-hold and idle bubbles all occur many times. Each edge is judged against a queue-based model that pops on an output transfer and pushes on an input transfer. Every held word is compared with the head of that queue, so a dropped, duplicated or overwritten result appears as a mismatch.

// File: rtl/subword_shuffle_pkg.sv
package subword_shuffle_pkg;
  localparam int WORD_W = 64;
  localparam int LANE_W = 16;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int SH_W   = $clog2(LANE_W);
  localparam int SEL_W  = $clog2(LANES);
  localparam int PERM_W = LANES * SEL_W;

  typedef enum logic [2:0] {
    OP_SHR_S  = 3'd0,
    OP_SHR_U  = 3'd1,
    OP_SHL    = 3'd2,
    OP_MIX16L = 3'd3,
    OP_MIX16R = 3'd4,
    OP_MIX32L = 3'd5,
    OP_MIX32R = 3'd6,
    OP_PERM   = 3'd7
  } sop_e;
endpackage

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int WORD_W = 64,
  parameter int LANE_W = 16,
  localparam int LANES = WORD_W / LANE_W,
  localparam int SH_W  = $clog2(LANE_W)
) (
  input  logic [WORD_W-1:0] src,
  input  logic [SH_W-1:0]   amt,
  output logic [WORD_W-1:0] shr_s,
  output logic [WORD_W-1:0] shr_u,
  output logic [WORD_W-1:0] shl
);
  // Each lane gets its own shifter, so no carry path crosses a boundary.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane;
    assign lane = src[g*LANE_W +: LANE_W];
    assign shr_s[g*LANE_W +: LANE_W] = LANE_W'($signed(lane) >>> amt);
    assign shr_u[g*LANE_W +: LANE_W] = lane >> amt;
    assign shl[g*LANE_W +: LANE_W]   = lane << amt;
  end
endmodule

// File: rtl/mix_unit.sv
module mix_unit #(
  parameter int WORD_W = 64,
  parameter int GRAN   = 16,
  localparam int PIECES = WORD_W / GRAN
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] mix_l,
  output logic [WORD_W-1:0] mix_r
);
  // Pieces numbered from the left; piece p sits at bit WORD_W-1-p*GRAN.
  for (genvar k = 0; k < PIECES / 2; k++) begin : g_pair
    localparam int HI_E = WORD_W - 1 - (2*k)   * GRAN;
    localparam int HI_O = WORD_W - 1 - (2*k+1) * GRAN;
    assign mix_l[HI_E -: GRAN] = a[HI_E -: GRAN];
    assign mix_l[HI_O -: GRAN] = b[HI_E -: GRAN];
    assign mix_r[HI_E -: GRAN] = a[HI_O -: GRAN];
    assign mix_r[HI_O -: GRAN] = b[HI_O -: GRAN];
  end
endmodule

// File: rtl/permute_unit.sv
module permute_unit #(
  parameter int WORD_W = 64,
  parameter int LANE_W = 16,
  localparam int LANES  = WORD_W / LANE_W,
  localparam int SEL_W  = $clog2(LANES),
  localparam int PERM_W = LANES * SEL_W
) (
  input  logic [WORD_W-1:0] src,
  input  logic [PERM_W-1:0] sel,
  output logic [WORD_W-1:0] dst
);
  logic [LANE_W-1:0] lane_l [LANES];

  for (genvar s = 0; s < LANES; s++) begin : g_unpack
    assign lane_l[s] = src[(LANES-1-s)*LANE_W +: LANE_W];
  end

  // Destination lane k from the left uses the k-th field from the top.
  for (genvar k = 0; k < LANES; k++) begin : g_dest
    logic [SEL_W-1:0] fld;
    assign fld = sel[(LANES-1-k)*SEL_W +: SEL_W];
    assign dst[(LANES-1-k)*LANE_W +: LANE_W] = lane_l[fld];
  end
endmodule

// File: rtl/subword_shuffle_unit.sv
module subword_shuffle_unit
  import subword_shuffle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [WORD_W-1:0] req_src_a,
  input  logic [WORD_W-1:0] req_src_b,
  input  logic [SH_W-1:0]   req_shamt,
  input  logic [PERM_W-1:0] req_perm,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_data
);
  logic [WORD_W-1:0] shr_s, shr_u, shl;
  logic [WORD_W-1:0] m16_l, m16_r, m32_l, m32_r, perm;
  logic [WORD_W-1:0] result;
  logic              take;

  lane_shifter #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_shift (
    .src(req_src_a), .amt(req_shamt),
    .shr_s(shr_s), .shr_u(shr_u), .shl(shl)
  );

  mix_unit #(.WORD_W(WORD_W), .GRAN(LANE_W)) u_mix16 (
    .a(req_src_a), .b(req_src_b), .mix_l(m16_l), .mix_r(m16_r)
  );

  mix_unit #(.WORD_W(WORD_W), .GRAN(2*LANE_W)) u_mix32 (
    .a(req_src_a), .b(req_src_b), .mix_l(m32_l), .mix_r(m32_r)
  );

  permute_unit #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_perm (
    .src(req_src_a), .sel(req_perm), .dst(perm)
  );

  always_comb begin
    unique case (sop_e'(req_op))
      OP_SHR_S:  result = shr_s;
      OP_SHR_U:  result = shr_u;
      OP_SHL:    result = shl;
      OP_MIX16L: result = m16_l;
      OP_MIX16R: result = m16_r;
      OP_MIX32L: result = m32_l;
      OP_MIX32R: result = m32_r;
      OP_PERM:   result = perm;
      default:   result = '0;
    endcase
  end

  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      if (req_ready) res_valid <= req_valid;
      if (take)      res_data  <= result;
    end
  end
endmodule

// File: rtl/subword_shuffle_chk.sv
module subword_shuffle_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_op,
  input logic [63:0] req_src_a,
  input logic [3:0]  req_shamt,
  input logic [7:0]  req_perm,
  input logic        res_valid,
  input logic        res_ready,
  input logic [63:0] res_data
);
  assert_ready_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> req_ready);

  assert_accept_shows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  assert_drain_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !req_valid) |=> !res_valid);

  assert_lsr_top_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 3'd1 && req_shamt == 4'd15)
      |=> ((res_data & 64'hFFFE_FFFE_FFFE_FFFE) == 64'd0));

  assert_perm_identity_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 3'd7 && req_perm == 8'h1B)
      |=> (res_data == $past(req_src_a)));
endmodule

bind subword_shuffle_unit subword_shuffle_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_src_a(req_src_a), .req_shamt(req_shamt),
  .req_perm(req_perm), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data)
);

// File: tb/subword_shuffle_unit_tb.sv
`timescale 1ns/1ps
module subword_shuffle_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [63:0] req_src_a = '0;
  logic [63:0] req_src_b = '0;
  logic [3:0]  req_shamt = '0;
  logic [7:0]  req_perm = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [63:0] res_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] expq[$];

  always #2 clk = ~clk;

  subword_shuffle_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src_a(req_src_a), .req_src_b(req_src_b),
    .req_shamt(req_shamt), .req_perm(req_perm), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  function automatic logic [15:0] lane_of(logic [63:0] w, int i);
    return w[63-16*i -: 16];
  endfunction

  function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a,
      logic [63:0] b, logic [3:0] sh, logic [7:0] pi);
    logic [63:0] r = '0;
    logic [15:0] l, o;
    int s = int'(sh);
    case (op)
      3'd0, 3'd1, 3'd2: begin
        for (int i = 0; i < 4; i++) begin
          l = lane_of(a, i);
          for (int k = 0; k < 16; k++) begin
            if (op == 3'd2) o[k] = (k >= s) ? l[k-s] : 1'b0;
            else if (k + s < 16) o[k] = l[k+s];
            else o[k] = (op == 3'd0) ? l[15] : 1'b0;
          end
          r[63-16*i -: 16] = o;
        end
      end
      3'd3: r = {lane_of(a,0), lane_of(b,0), lane_of(a,2), lane_of(b,2)};
      3'd4: r = {lane_of(a,1), lane_of(b,1), lane_of(a,3), lane_of(b,3)};
      3'd5: r = {a[63:32], b[63:32]};
      3'd6: r = {a[31:0], b[31:0]};
      default: begin
        for (int i = 0; i < 4; i++)
          r[63-16*i -: 16] = lane_of(a, int'(pi[7-2*i -: 2]));
      end
    endcase
    return r;
  endfunction

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3, 3'd4: return "R8";
      3'd5, 3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic one_op(logic [2:0] op, logic [63:0] a, logic [63:0] b,
      logic [3:0] sh, logic [7:0] pi, output logic [63:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_src_a = a; req_src_b = b;
    req_shamt = sh; req_perm = pi; res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(res_valid == 1'b1, "R1", {63'd0, res_valid}, 64'd1);
    r = res_data;
    check(r == model(op, a, b, sh, pi), req_of(op), r, model(op, a, b, sh, pi));
  endtask

  logic [63:0] dir_a [8] = '{64'h8000_7FFF_1234_FFFF, 64'hF00F_0001_8001_4000,
                             64'h1111_2222_3333_4444, 64'hAAAA_5555_C3C3_0F0F,
                             64'h8000_8000_8000_8000, 64'hFFFF_0000_FFFF_0000,
                             64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_CAFE_F00D};

  initial begin
    logic [63:0] rows [4];
    logic [63:0] t [4];
    logic [63:0] col [4];
    logic [63:0] expc;
    bit pending = 1'b0;
    bit stalled;
    logic [2:0] dop;

    // R3: reset state
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R3", {63'd0, res_valid}, 64'd0);
    check(req_ready == 1'b1, "R1", {63'd0, req_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0, "R3", {63'd0, res_valid}, 64'd0);

    // Directed: every opcode, shamt 0 and 15 (R7), perm identity/reversal/repeat
    for (int i = 0; i < 8; i++) begin
      for (int o = 0; o < 8; o++) begin
        logic [63:0] r;
        one_op(3'(o), dir_a[i], dir_a[7-i], (i[0]) ? 4'd15 : 4'd0,
               (i < 3) ? 8'h1B : (i < 5) ? 8'hE4 : 8'h50, r);
        if (o <= 2 && !i[0])
          check(r == dir_a[i], "R7", r, dir_a[i]);
      end
    end

    // R11: src_b changes nothing for shift/permute; shamt changes nothing for mix
    begin
      logic [63:0] r1, r2;
      one_op(3'd0, dir_a[0], 64'd0, 4'd5, 8'h00, r1);
      one_op(3'd0, dir_a[0], '1, 4'd5, 8'hFF, r2);
      check(r1 == r2, "R11", r2, r1);
      one_op(3'd7, dir_a[6], 64'd0, 4'd0, 8'h9C, r1);
      one_op(3'd7, dir_a[6], '1, 4'd9, 8'h9C, r2);
      check(r1 == r2, "R11", r2, r1);
      one_op(3'd3, dir_a[6], dir_a[7], 4'd0, 8'h00, r1);
      one_op(3'd3, dir_a[6], dir_a[7], 4'd13, 8'hA7, r2);
      check(r1 == r2, "R11", r2, r1);
    end

    // R12: 4x4 transpose with eight mixes
    rows[0] = 64'h00A0_00A1_00A2_00A3; rows[1] = 64'h00B0_00B1_00B2_00B3;
    rows[2] = 64'h00C0_00C1_00C2_00C3; rows[3] = 64'h00D0_00D1_00D2_00D3;
    one_op(3'd3, rows[0], rows[1], 4'd0, 8'd0, t[0]);
    one_op(3'd4, rows[0], rows[1], 4'd0, 8'd0, t[1]);
    one_op(3'd3, rows[2], rows[3], 4'd0, 8'd0, t[2]);
    one_op(3'd4, rows[2], rows[3], 4'd0, 8'd0, t[3]);
    one_op(3'd5, t[0], t[2], 4'd0, 8'd0, col[0]);
    one_op(3'd5, t[1], t[3], 4'd0, 8'd0, col[1]);
    one_op(3'd6, t[0], t[2], 4'd0, 8'd0, col[2]);
    one_op(3'd6, t[1], t[3], 4'd0, 8'd0, col[3]);
    for (int c = 0; c < 4; c++) begin
      expc = {lane_of(rows[0],c), lane_of(rows[1],c), lane_of(rows[2],c), lane_of(rows[3],c)};
      check(col[c] == expc, "R12", col[c], expc);
    end
    @(negedge clk);
    check(res_valid == 1'b0, "R1", {63'd0, res_valid}, 64'd0);

    // Random traffic with back-pressure: R1, R2 and all opcodes
    stalled = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (res_valid) begin
        if (expq.size() == 0)
          check(1'b0, "R1", res_data, 64'd0);
        else
          check(res_data == expq[0], stalled ? "R2" : req_of(dop), res_data, expq[0]);
      end else begin
        check(!stalled, "R2", 64'd0, 64'd1);
      end
      if (!pending) begin
        req_valid = ($urandom_range(0, 9) < 7);
        req_op    = 3'($urandom_range(0, 7));
        req_src_a = {$urandom, $urandom};
        req_src_b = {$urandom, $urandom};
        req_shamt = 4'($urandom_range(0, 15));
        req_perm  = 8'($urandom);
      end
      res_ready = ($urandom_range(0, 9) < 6);
      #1;
      check(req_ready == (!res_valid || res_ready), "R1",
            {63'd0, req_ready}, {63'd0, (!res_valid || res_ready)});
      stalled = res_valid && !res_ready;
      if (res_valid && res_ready) void'(expq.pop_front());
      if (req_valid && req_ready) begin
        expq.push_back(model(req_op, req_src_a, req_src_b, req_shamt, req_perm));
        dop = req_op;
        pending = 1'b0;
      end else begin
        pending = req_valid;
      end
      @(negedge clk);
    end
    finish_run();
  end
endmodule